// File: doc/BRIEF.md
# Interrupt Controller Base and Identity Register

This block keeps the per-processor interrupt controller's base-address register together with its identity state. The base register holds a relocatable address field, a global enable flag, an extended-addressing flag and a flag marking the boot processor. The identity state has two parts: a wide initial identifier, set once before operation, and a short 8-bit current identifier that software may rewrite while extended addressing is off.

Other logic reads the base value and the three mode flags directly from the ports. The identifier read port shows the full wide identifier while extended addressing is on and the zero-extended short identifier while it is off. Turning extended addressing on discards any software change to the short identifier by reloading it from the wide one. A soft reset rebuilds the base register from its default and keeps only the boot-processor flag. A separate input lets the platform mark or unmark the processor as the boot processor.

All state is registered. Every input takes effect at the next rising clock edge, and the outputs are driven directly from the registers.

Top module: `apic_base_ident`

## Requirements
- R1: A base write that sets bit 10 (extended addressing) while the stored bit 10 is clear reloads the short identifier from the low 8 bits of the wide identifier.
- R2: A soft reset sets the base register to 0xFEE00000 in bits 31:12, sets bit 11 (enable), keeps the previous bit 8 (boot processor) and clears every other bit.
- R3: A soft reset reloads the short identifier from the low 8 bits of the wide identifier.
- R4: The identifier read port returns the 32-bit wide identifier when bit 10 is set, and otherwise returns the 8-bit short identifier zero-extended to 32 bits.
- R5: A boot-processor designation writes only bit 8 of the base register and leaves bits 31:9 and 7:0 unchanged.
- R6: An identifier load stores the full 32-bit value as the wide identifier and its low 8 bits as the short identifier.
- R7: A software identifier write with bit 10 clear replaces the short identifier and leaves the wide identifier unchanged.
- R8: A software identifier write with bit 10 set has no effect.
- R9: A base write that clears bit 10, or that leaves it at its stored value, does not change the short identifier.
- R10: After the synchronous hard reset, the base register reads 0xFEE00800 and both identifiers hold the RESET_ID parameter (the short identifier holds its low 8 bits).
- R11: The mode outputs show bits 11, 10 and 8 of the stored base value, and a base write is read back unchanged on the next cycle.
- R12: The priority order in one cycle is soft reset, then base write, then boot designation. A soft reset overrides a base write and an identifier write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Soft reset: rebuild base, keep boot flag, reload short identifier |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | Base register write value |
| base_rdata | output | 32 | Stored base register value |
| boot_set | input | 1 | Boot-processor designation strobe |
| boot_val | input | 1 | Value to write into the boot-processor flag |
| id_load | input | 1 | Load the wide and short identifiers |
| id_load_data | input | 32 | Wide identifier value to load |
| id_we | input | 1 | Software write of the short identifier |
| id_wdata | input | 8 | Short identifier write value |
| id_rdata | output | 32 | Identifier as seen under the current addressing mode |
| mode_enable | output | 1 | Global enable flag (bit 11) |
| mode_ext | output | 1 | Extended addressing flag (bit 10) |
| mode_boot | output | 1 | Boot-processor flag (bit 8) |

## Verification
A wrong short identifier stays hidden while extended addressing is on. It shows up on the identifier read port one cycle after any base write that clears bit 10. For that reason the tests leave extended mode on purpose to expose the reload. A corrupted wide identifier appears on the read port one cycle after extended mode is entered, so wide-identifier errors are checked by entering extended mode. Base and flag errors appear on the base and mode ports one cycle after the write, designation or reset that caused them.

// File: rtl/apicb_pkg.sv
package apicb_pkg;

    localparam int REG_W   = 32;
    localparam int SHORT_W = 8;
    localparam int ADDR_W  = 20;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;     // bits 31:12
        logic              enable;   // bit 11
        logic              ext;      // bit 10
        logic              rsv9;     // bit 9
        logic              boot;     // bit 8
        logic [7:0]        low;      // bits 7:0
    } base_t;

    typedef struct packed {
        logic [REG_W-1:0]   wide;
        logic [SHORT_W-1:0] short_id;
    } ident_t;

    function automatic base_t rebuild_base(logic [ADDR_W-1:0] addr, logic boot);
        base_t b;
        b        = '0;
        b.addr   = addr;
        b.enable = 1'b1;
        b.boot   = boot;
        return b;
    endfunction

endpackage

// File: rtl/apicb_base_reg.sv
module apicb_base_reg
    import apicb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEFAULT_ADDR = 20'hFEE00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             base_we,
    input  logic [REG_W-1:0] base_wdata,
    input  logic             boot_set,
    input  logic             boot_val,
    output base_t            base_q,
    output logic             ext_rise
);

    base_t wr_view;
    assign wr_view = base_t'(base_wdata);

    assign ext_rise = base_we && !soft_rst && !base_q.ext && wr_view.ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= rebuild_base(DEFAULT_ADDR, 1'b0);
        end else if (soft_rst) begin
            base_q <= rebuild_base(DEFAULT_ADDR, base_q.boot);
        end else if (base_we) begin
            base_q <= wr_view;
        end else if (boot_set) begin
            base_q.boot <= boot_val;
        end
    end

    assert_soft_rebuild_R2: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (base_q == rebuild_base(DEFAULT_ADDR, $past(base_q.boot))));

    assert_boot_only_R5: assert property (@(posedge clk) disable iff (rst)
        (boot_set && !soft_rst && !base_we) |=>
            ($stable(base_q.addr) && $stable(base_q.enable) && $stable(base_q.ext)
             && $stable(base_q.rsv9) && $stable(base_q.low) && base_q.boot == $past(boot_val)));

    assert_write_back_R11: assert property (@(posedge clk) disable iff (rst)
        (base_we && !soft_rst) |=> (base_q == $past(base_wdata)));

endmodule

// File: rtl/apicb_ident_reg.sv
module apicb_ident_reg
    import apicb_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_ID = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               ext_rise,
    input  logic               ext_mode,
    input  logic               load_valid,
    input  logic [REG_W-1:0]   load_data,
    input  logic               wr_valid,
    input  logic [SHORT_W-1:0] wr_data,
    output ident_t             ident_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ident_q.wide     <= RESET_ID;
            ident_q.short_id <= RESET_ID[SHORT_W-1:0];
        end else if (soft_rst) begin
            ident_q.short_id <= ident_q.wide[SHORT_W-1:0];
        end else if (load_valid) begin
            ident_q.wide     <= load_data;
            ident_q.short_id <= load_data[SHORT_W-1:0];
        end else if (ext_rise) begin
            ident_q.short_id <= ident_q.wide[SHORT_W-1:0];
        end else if (wr_valid && !ext_mode) begin
            ident_q.short_id <= wr_data;
        end
    end

    assert_ext_reload_R1: assert property (@(posedge clk) disable iff (rst)
        (ext_rise && !load_valid) |=> (ident_q.short_id == $past(ident_q.wide[SHORT_W-1:0])));

    assert_soft_reload_R3: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ident_q.short_id == $past(ident_q.wide[SHORT_W-1:0])));

    assert_load_both_R6: assert property (@(posedge clk) disable iff (rst)
        (load_valid && !soft_rst) |=>
            (ident_q.wide == $past(load_data) && ident_q.short_id == $past(load_data[SHORT_W-1:0])));

    assert_ext_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && ext_mode && !soft_rst && !load_valid && !ext_rise) |=> $stable(ident_q));

    assert_wide_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_valid) |=> $stable(ident_q.wide));

endmodule

// File: rtl/apicb_id_view.sv
module apicb_id_view
    import apicb_pkg::*;
(
    input  logic             ext_mode,
    input  ident_t           ident,
    output logic [REG_W-1:0] id_rdata
);

    logic [REG_W-1:0] short_ext;

    generate
        if (REG_W > SHORT_W) begin : g_pad
            assign short_ext = {{(REG_W-SHORT_W){1'b0}}, ident.short_id};
        end else begin : g_nopad
            assign short_ext = ident.short_id[REG_W-1:0];
        end
    endgenerate

    assign id_rdata = ext_mode ? ident.wide : short_ext;

    always_comb begin
        if (!ext_mode) begin
            assert_short_zero_R4: assert (id_rdata[REG_W-1:SHORT_W] == '0);
        end
    end

endmodule

// File: rtl/apic_base_ident.sv
module apic_base_ident
    import apicb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEFAULT_ADDR = 20'hFEE00,
    parameter logic [REG_W-1:0]  RESET_ID     = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               base_we,
    input  logic [REG_W-1:0]   base_wdata,
    output logic [REG_W-1:0]   base_rdata,
    input  logic               boot_set,
    input  logic               boot_val,
    input  logic               id_load,
    input  logic [REG_W-1:0]   id_load_data,
    input  logic               id_we,
    input  logic [SHORT_W-1:0] id_wdata,
    output logic [REG_W-1:0]   id_rdata,
    output logic               mode_enable,
    output logic               mode_ext,
    output logic               mode_boot
);

    base_t  base_q;
    ident_t ident_q;
    logic   ext_rise;

    apicb_base_reg #(.DEFAULT_ADDR(DEFAULT_ADDR)) u_base (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .base_we   (base_we),
        .base_wdata(base_wdata),
        .boot_set  (boot_set),
        .boot_val  (boot_val),
        .base_q    (base_q),
        .ext_rise  (ext_rise)
    );

    apicb_ident_reg #(.RESET_ID(RESET_ID)) u_ident (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .ext_rise  (ext_rise),
        .ext_mode  (base_q.ext),
        .load_valid(id_load),
        .load_data (id_load_data),
        .wr_valid  (id_we),
        .wr_data   (id_wdata),
        .ident_q   (ident_q)
    );

    apicb_id_view u_view (
        .ext_mode(base_q.ext),
        .ident   (ident_q),
        .id_rdata(id_rdata)
    );

    assign base_rdata  = base_q;
    assign mode_enable = base_q.enable;
    assign mode_ext    = base_q.ext;
    assign mode_boot   = base_q.boot;

    assert_prio_soft_R12: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && base_we) |=> (base_rdata[31:12] == DEFAULT_ADDR && !mode_ext));

    assert_keep_ext_R9: assert property (@(posedge clk) disable iff (rst)
        (base_we && !soft_rst && !id_load && !id_we && !(base_wdata[10] && !mode_ext))
            |=> $stable(ident_q.short_id));

endmodule

// File: tb/sim_apic_base_ident.sv
module sim_apic_base_ident;

    logic        clk = 1'b0;
    logic        rst, soft_rst, base_we, boot_set, boot_val, id_load, id_we;
    logic [31:0] base_wdata, id_load_data, base_rdata, id_rdata;
    logic [7:0]  id_wdata;
    logic        mode_enable, mode_ext, mode_boot;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    apic_base_ident u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .base_we(base_we), .base_wdata(base_wdata), .base_rdata(base_rdata),
        .boot_set(boot_set), .boot_val(boot_val),
        .id_load(id_load), .id_load_data(id_load_data),
        .id_we(id_we), .id_wdata(id_wdata), .id_rdata(id_rdata),
        .mode_enable(mode_enable), .mode_ext(mode_ext), .mode_boot(mode_boot)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic idle();
        rst = 0; soft_rst = 0; base_we = 0; boot_set = 0; boot_val = 0;
        id_load = 0; id_we = 0; base_wdata = '0; id_load_data = '0; id_wdata = '0;
    endtask

    // drive at negedge, one rising edge, back to negedge for sampling
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic t_hard_reset();
        @(negedge clk); idle(); rst = 1;
        step(); step();
        chk("R10 base", base_rdata, 32'hFEE00800);
        chk("R10 id", id_rdata, 32'h0);
        chk("R11 flags", {29'd0, mode_enable, mode_ext, mode_boot}, 32'h4);
    endtask

    task automatic t_id_load();
        id_load = 1; id_load_data = 32'h0001_2345; step();
        chk("R6 short after load", id_rdata, 32'h45);
        id_we = 1; id_wdata = 8'h77; step();
        chk("R7 short write", id_rdata, 32'h77);
    endtask

    task automatic t_ext_mode();
        base_we = 1; base_wdata = 32'hFEE00C00; step();
        chk("R11 readback", base_rdata, 32'hFEE00C00);
        chk("R11 ext flag", {31'd0, mode_ext}, 32'h1);
        chk("R4 R7 wide view", id_rdata, 32'h0001_2345);
        id_we = 1; id_wdata = 8'h99; step();
        chk("R8 write ignored in ext", id_rdata, 32'h0001_2345);
        base_we = 1; base_wdata = 32'hFEE00800; step();
        chk("R1 R8 R9 short reloaded", id_rdata, 32'h45);
    endtask

    task automatic t_keep_mode();
        id_we = 1; id_wdata = 8'h33; step();
        chk("R7 short write", id_rdata, 32'h33);
        base_we = 1; base_wdata = 32'hFED00800; step();
        chk("R9 no side effect", id_rdata, 32'h33);
        chk("R11 readback", base_rdata, 32'hFED00800);
    endtask

    task automatic t_boot();
        boot_set = 1; boot_val = 1; step();
        chk("R5 set boot", base_rdata, 32'hFED00900);
        chk("R11 boot flag", {31'd0, mode_boot}, 32'h1);
        boot_set = 1; boot_val = 0; step();
        chk("R5 clear boot", base_rdata, 32'hFED00800);
    endtask

    task automatic t_soft_reset();
        id_we = 1; id_wdata = 8'h66; step();
        boot_set = 1; boot_val = 1; step();
        soft_rst = 1; step();
        chk("R2 keep boot", base_rdata, 32'hFEE00900);
        chk("R3 short reload", id_rdata, 32'h45);
        boot_set = 1; boot_val = 0; step();
        soft_rst = 1; step();
        chk("R2 no boot", base_rdata, 32'hFEE00800);
    endtask

    task automatic t_priority();
        soft_rst = 1; base_we = 1; base_wdata = 32'h0000_0400;
        id_we = 1; id_wdata = 8'h11; step();
        chk("R12 base", base_rdata, 32'hFEE00800);
        chk("R12 id", id_rdata, 32'h45);
    endtask

    initial begin
        idle();
        t_hard_reset();
        t_id_load();
        t_ext_mode();
        t_keep_mode();
        t_boot();
        t_soft_reset();
        t_priority();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule